// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns the fetch and data-access needs of an 8-bit controller core into timed external bus cycles over a 16-bit address space. Every machine cycle is twelve clocks long and holds two code-fetch slots. Each slot starts with a two-clock address-latch pulse, during which the shared low byte lane drives the low address byte. A three-clock program-read strobe follows. The byte on the lane is captured on the last clock of that strobe and handed to the core as the fetched code byte. Fetches below the on-chip code boundary are served inside the chip unless the force-external input is high. Such fetches keep their latch pulse but produce no program-read strobe and no code byte.

A data access occupies two machine cycles. The core raises a request with a direction, an address form, an address, write data and a page value. The request is taken on the last clock of a machine cycle. In the first cycle of the pair, the second latch pulse carries the data address and its program-read strobe is dropped. In the second cycle, the first slot loses both its latch pulse and its program-read strobe and carries the data strobe. The pair therefore has three latch pulses and two program-read strobes. For the long form the high byte lane holds the upper address byte. For the short form it holds the page value.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is active, ale is 0, psen_n, rd_n and wr_n are 1, ad_oe is 0, and ad_out and a_hi are all ones.
- R2: The first clock after reset is phase 0 of a 12-clock machine cycle. ale is high in phases 0-1 and 6-7, except as R7 states.
- R3: fetch_addr and force_ext are sampled in phase 11 for slot A and in phase 5 for slot B. An external slot has psen_n low in phases 2-4 (slot A) or 8-10 (slot B) with ad_oe low. ad_out carries the fetch address low byte while ale is high. a_hi carries its high byte in phases 0-4 and 6-10. ad_out and a_hi are all ones whenever neither R3 nor R7-R10 drives them.
- R4: ad_in is captured in the last psen_n-low clock, phase 4 or 10. In the next clock code_byte holds it and code_vld is high for exactly that one clock.
- R5: A slot whose address is below INT_BYTES while force_ext is 0 produces no psen_n pulse and no code_vld. Its ale pulse still occurs.
- R6: A request with dat_req high in phase 11 is accepted, unless that phase ends the first cycle of a pair. dat_ack is then high in the following phase 0 only, and dat_wr, dat_short, dat_addr, dat_wdata and page_reg are latched.
- R7: In the first cycle of a pair, the phase 6-7 ale pulse carries the data address low byte on ad_out and slot B has no psen_n. In the second cycle, phases 0-1 have no ale and slot A has no psen_n.
- R8: For a write (dat_wr=1), wr_n is low in phases 1-4 of the second cycle. ad_oe is high and ad_out holds the write data in phases 0-5.
- R9: For a read (dat_wr=0), rd_n is low in phases 1-4 of the second cycle with ad_oe low. ad_in is captured in phase 4, and rdata with a one-clock rdata_vld appears in phase 5.
- R10: From phase 6 of the first cycle to phase 5 of the second, a_hi holds dat_addr[15:8] when dat_short=0 and page_reg when dat_short=1.
- R11: At most one of psen_n, rd_n, wr_n is low at a time, and none is low while ale is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_ext | input | 1 | Send every fetch to the external bus |
| fetch_addr | input | 16 | Code fetch address from the core |
| dat_req | input | 1 | Data access request |
| dat_wr | input | 1 | 1 = write, 0 = read |
| dat_short | input | 1 | 1 = short form (page value on high lane) |
| dat_addr | input | 16 | Data address (low byte only for short form) |
| dat_wdata | input | 8 | Write data |
| page_reg | input | 8 | Page value for short-form accesses |
| dat_ack | output | 1 | Request accepted pulse |
| code_byte | output | 8 | Fetched code byte |
| code_vld | output | 1 | code_byte valid pulse |
| rdata | output | 8 | Data read result |
| rdata_vld | output | 1 | rdata valid pulse |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address/data lane output value |
| ad_oe | output | 1 | Low lane drive enable |
| ad_in | input | 8 | Low lane input value |
| a_hi | output | 8 | High address lane |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit lanes and a 16384-byte on-chip code boundary. With these values the directed fetches at 0x3FFF and 0x4000 fall on each side of that boundary, and full-range random fetch addresses land on both sides about as often as the address split suggests. The 8-bit lane width lets the bench model external memory as a simple function of the address, so every captured code byte and read byte can be predicted exactly. Back-to-back data pairs, both address forms and both directions are covered, and force_ext varies per slot.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int ADDR_W    = 16,
  parameter int LANE_W    = 8,
  parameter int INT_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_ext,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              dat_req,
  input  logic              dat_wr,
  input  logic              dat_short,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic [LANE_W-1:0] dat_wdata,
  input  logic [ADDR_W-LANE_W-1:0] page_reg,
  output logic              dat_ack,
  output logic [LANE_W-1:0] code_byte,
  output logic              code_vld,
  output logic [LANE_W-1:0] rdata,
  output logic              rdata_vld,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [LANE_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [LANE_W-1:0] ad_in,
  output logic [ADDR_W-LANE_W-1:0] a_hi
);
  localparam int HI_W = ADDR_W - LANE_W;
  localparam logic [ADDR_W-1:0] INT_LIM = ADDR_W'(INT_BYTES);
  localparam logic [3:0] LAST_PH = 4'd11;

  typedef enum logic [1:0] {DS_NONE, DS_ADDR, DS_XFER} dstate_t;

  logic [3:0]        ph;
  dstate_t           dst;
  logic [ADDR_W-1:0] faddr;
  logic              fext;
  logic              d_wr;
  logic [ADDR_W-1:0] d_addr;
  logic [LANE_W-1:0] d_wdata;

  wire last   = (ph == LAST_PH);
  wire accept = last && dat_req && (dst != DS_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= LAST_PH;
      dst       <= DS_NONE;
      faddr     <= '0;
      fext      <= 1'b0;
      d_wr      <= 1'b0;
      d_addr    <= '0;
      d_wdata   <= '0;
      dat_ack   <= 1'b0;
      code_byte <= '0;
      code_vld  <= 1'b0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      ph      <= last ? 4'd0 : ph + 4'd1;
      dat_ack <= accept;
      if (last)
        dst <= accept ? DS_ADDR : (dst == DS_ADDR) ? DS_XFER : DS_NONE;
      if (last || ph == 4'd5) begin
        faddr <= fetch_addr;
        fext  <= force_ext || (fetch_addr >= INT_LIM);
      end
      if (accept) begin
        d_wr    <= dat_wr;
        d_addr  <= {dat_short ? page_reg : dat_addr[ADDR_W-1:LANE_W], dat_addr[LANE_W-1:0]};
        d_wdata <= dat_wdata;
      end
      code_vld <= !psen_n && (ph == 4'd4 || ph == 4'd10);
      if (!psen_n && (ph == 4'd4 || ph == 4'd10)) code_byte <= ad_in;
      rdata_vld <= !rd_n && ph == 4'd4;
      if (!rd_n && ph == 4'd4) rdata <= ad_in;
    end
  end

  wire slot_a = (ph >= 4'd2) && (ph <= 4'd4);
  wire slot_b = (ph >= 4'd8) && (ph <= 4'd10);
  wire ale_a  = (ph <= 4'd1) && (dst != DS_XFER);
  wire ale_b  = (ph == 4'd6) || (ph == 4'd7);
  wire dwin   = (dst == DS_XFER) && (ph <= 4'd5);
  wire strb   = (dst == DS_XFER) && (ph >= 4'd1) && (ph <= 4'd4);
  wire hiwin  = ((dst == DS_ADDR) && (ph >= 4'd6)) || dwin;
  wire fwin   = (ph <= 4'd4) || ((ph >= 4'd6) && (ph <= 4'd10));

  assign ale    = ale_a || ale_b;
  assign psen_n = !(fext && ((slot_a && dst != DS_XFER) || (slot_b && dst != DS_ADDR)));
  assign rd_n   = !(strb && !d_wr);
  assign wr_n   = !(strb && d_wr);
  assign ad_oe  = ale || (dwin && d_wr);
  assign ad_out = (ale_b && dst == DS_ADDR) ? d_addr[LANE_W-1:0] :
                  ale                       ? faddr[LANE_W-1:0]  :
                  (dwin && d_wr)            ? d_wdata            : '1;
  assign a_hi   = hiwin ? d_addr[ADDR_W-1:LANE_W] :
                  fwin  ? faddr[ADDR_W-1:LANE_W]  : {HI_W{1'b1}};

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R11
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n)); // R11
  AST_ALE_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale); // R2
  AST_PSEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !ad_oe); // R3
  AST_CODE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |=> !code_vld); // R4
  AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ack |-> $past(dat_req)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && $stable(ad_out))); // R8
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R9
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(a_hi)); // R10
endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_ext = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic dat_req = 1'b0, dat_wr = 1'b0, dat_short = 1'b0;
  logic [15:0] dat_addr = '0;
  logic [7:0] dat_wdata = '0, page_reg = '0;
  logic dat_ack, code_vld, rdata_vld, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0] code_byte, rdata, ad_out, ad_in, a_hi;

  int n_chk = 0, n_bad = 0, clk_cnt = 0;
  logic [3:0] bph = 4'd11;
  logic [1:0] bdst = 2'd0;
  logic [15:0] addrA = '0, addrB = '0;
  logic extA = 1'b0, extB = 1'b0;
  logic dwr = 1'b0;
  logic [7:0] dhi = '0, dlo = '0, dwd = '0;

  always #4 clk = ~clk;

  function automatic logic [7:0] cfn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] dfn(input logic [7:0] h, input logic [7:0] l);
    return h + (l * 8'd3) + 8'h11;
  endfunction

  assign ad_in = (bph <= 4'd5) ? ((bdst == 2'd2) ? dfn(dhi, dlo) : cfn(addrA)) : cfn(addrB);

  ext_bus_seq i_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .force_ext(force_ext), .fetch_addr(fetch_addr),
    .dat_req(dat_req), .dat_wr(dat_wr), .dat_short(dat_short), .dat_addr(dat_addr),
    .dat_wdata(dat_wdata), .page_reg(page_reg), .dat_ack(dat_ack),
    .code_byte(code_byte), .code_vld(code_vld), .rdata(rdata), .rdata_vld(rdata_vld),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi));

  always @(posedge clk) begin
    if (!rst_n) begin
      bph <= 4'd11; bdst <= 2'd0;
    end else begin
      bph <= (bph == 4'd11) ? 4'd0 : bph + 4'd1;
      if (bph == 4'd11) begin
        if (dat_req) begin
          bdst <= 2'd1; dwr <= dat_wr; dwd <= dat_wdata; dlo <= dat_addr[7:0];
          dhi <= dat_short ? page_reg : dat_addr[15:8];
        end else bdst <= (bdst == 2'd1) ? 2'd2 : 2'd0;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    clk_cnt++;
    if (clk_cnt > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog act=%0d exp=<150000", clk_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s phase=%0d act=%h exp=%h", tag, bph, act, exp);
    end
  endtask

  task automatic check_phase();
    logic ale_e, psn_e, rd_e, wr_e, oe_e, sa, sb, dw;
    logic [7:0] ado_e, hi_e;
    string tp;
    sa = (bph >= 4'd2 && bph <= 4'd4);
    sb = (bph >= 4'd8 && bph <= 4'd10);
    dw = (bdst == 2'd2 && bph <= 4'd5);
    ale_e = (bph <= 4'd1 && bdst != 2'd2) || bph == 4'd6 || bph == 4'd7;
    psn_e = !((sa && bdst != 2'd2 && extA) || (sb && bdst != 2'd1 && extB));
    rd_e  = !(bdst == 2'd2 && bph >= 4'd1 && bph <= 4'd4 && !dwr);
    wr_e  = !(bdst == 2'd2 && bph >= 4'd1 && bph <= 4'd4 && dwr);
    oe_e  = ale_e || (dw && dwr);
    if (ale_e && bph >= 4'd6 && bdst == 2'd1) ado_e = dlo;
    else if (ale_e) ado_e = (bph <= 4'd1) ? addrA[7:0] : addrB[7:0];
    else if (dw && dwr) ado_e = dwd;
    else ado_e = 8'hFF;
    if ((bdst == 2'd1 && bph >= 4'd6) || dw) hi_e = dhi;
    else if (bph <= 4'd4) hi_e = addrA[15:8];
    else if (bph >= 4'd6 && bph <= 4'd10) hi_e = addrB[15:8];
    else hi_e = 8'hFF;
    tp = (bdst != 2'd0) ? "R7" : "R2";
    chk(tp, {15'd0, ale}, {15'd0, ale_e});
    if (bdst != 2'd0) tp = "R7";
    else if ((sa && !extA) || (sb && !extB)) tp = "R5";
    else tp = "R3";
    chk(tp, {15'd0, psen_n}, {15'd0, psn_e});
    chk("R9", {15'd0, rd_n}, {15'd0, rd_e});
    chk("R8", {15'd0, wr_n}, {15'd0, wr_e});
    chk(dw ? (dwr ? "R8" : "R9") : "R3", {15'd0, ad_oe}, {15'd0, oe_e});
    chk((dw || (bdst == 2'd1 && bph >= 4'd6)) ? "R7" : "R3", {8'd0, ad_out}, {8'd0, ado_e});
    chk(((bdst == 2'd1 && bph >= 4'd6) || dw) ? "R10" : "R3", {8'd0, a_hi}, {8'd0, hi_e});
    if (bph == 4'd0) chk("R6", {15'd0, dat_ack}, {15'd0, bdst == 2'd1});
    else chk("R6", {15'd0, dat_ack}, 16'd0);
    if (bph == 4'd5) begin
      chk(extA ? "R4" : "R5", {15'd0, code_vld}, {15'd0, extA && bdst != 2'd2});
      if (extA && bdst != 2'd2) chk("R4", {8'd0, code_byte}, {8'd0, cfn(addrA)});
      chk("R9", {15'd0, rdata_vld}, {15'd0, bdst == 2'd2 && !dwr});
      if (bdst == 2'd2 && !dwr) chk("R9", {8'd0, rdata}, {8'd0, dfn(dhi, dlo)});
    end else if (bph == 4'd11) begin
      chk(extB ? "R4" : "R5", {15'd0, code_vld}, {15'd0, extB && bdst != 2'd1});
      if (extB && bdst != 2'd1) chk("R4", {8'd0, code_byte}, {8'd0, cfn(addrB)});
    end else begin
      chk("R4", {15'd0, code_vld}, 16'd0);
      chk("R9", {15'd0, rdata_vld}, 16'd0);
    end
  endtask

  task automatic drive_slot(input int k, input bit slot_b);
    logic [15:0] a;
    logic fe;
    a = 16'($urandom);
    fe = ($urandom_range(3) == 0);
    if (k == 0) begin a = slot_b ? 16'h4000 : 16'h3FFF; fe = 1'b0; end
    if (k == 1) begin a = slot_b ? 16'hFFFF : 16'h0123; fe = !slot_b; end
    if (k == 2) begin a = slot_b ? 16'h0000 : 16'h3FFE; fe = 1'b0; end
    fetch_addr = a; force_ext = fe;
    if (slot_b) begin addrB = a; extB = fe || (a >= 16'h4000); end
    else begin addrA = a; extA = fe || (a >= 16'h4000); end
  endtask

  task automatic drive_req(input int k);
    bit go;
    go = (bdst != 2'd1) && ((k >= 10) ? ($urandom_range(2) == 0) : (k == 3 || k == 5 || k == 7));
    dat_req = go;
    if (!go) return;
    dat_wr = ($urandom_range(1) == 1); dat_short = ($urandom_range(1) == 1);
    dat_addr = 16'($urandom); dat_wdata = 8'($urandom); page_reg = 8'($urandom);
    if (k == 3) begin dat_wr = 1'b1; dat_short = 1'b0; dat_addr = 16'hABCD; dat_wdata = 8'h5E; end
    if (k == 5) begin dat_wr = 1'b0; dat_short = 1'b1; dat_addr = 16'h9942; page_reg = 8'h7E; end
    if (k == 7) begin dat_wr = 1'b1; dat_short = 1'b1; dat_addr = 16'h0081; page_reg = 8'hC3; dat_wdata = 8'h00; end
  endtask

  initial begin
    int k;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", {15'd0, ale}, 16'd0);
    chk("R1", {15'd0, psen_n}, 16'd1);
    chk("R1", {15'd0, rd_n}, 16'd1);
    chk("R1", {15'd0, wr_n}, 16'd1);
    chk("R1", {15'd0, ad_oe}, 16'd0);
    chk("R1", {8'd0, ad_out}, 16'h00FF);
    chk("R1", {8'd0, a_hi}, 16'h00FF);
    chk("R1", {14'd0, code_vld, dat_ack}, 16'd0);
    rst_n = 1'b1;
    k = 0;
    drive_slot(k, 1'b0);
    while (k < 300) begin
      @(negedge clk);
      check_phase();
      dat_req = 1'b0;
      if (bph == 4'd5) drive_slot(k, 1'b1);
      if (bph == 4'd11) begin
        k++;
        drive_slot(k, 1'b0);
        drive_req(k);
      end
    end
    summary();
    $finish;
  end
endmodule